// File: doc/BRIEF.md
# Last Reset Cause Recorder

This block keeps a record of why the system last went through reset. Event detectors elsewhere on the board raise single-cycle strobes, one per possible cause (power loss, thermal shutdown, watchdogs from different sources, power-button presses, firmware and software requests and so on). The recorder latches the cause into a one-hot vector. A new cause always overwrites the old one, so the vector names only the latest reset and never accumulates history.

The record sits in the power-on reset domain. The system reset that the record describes does not clear it, so software that boots after that reset can read the cause through a small read-only register port. When strobes collide in the same cycle, a fixed priority chooses the winner, and power-loss causes rank highest. A one-cycle capture pulse marks each new latch.

Top module: `rstc_recorder`

## Requirements
- R1: After power-on reset the cause vector is all zero, the capture pulse is low, and a read of either register returns zero.
- R2: At most one bit of the cause vector is 1 at any time.
- R3: A strobe on a single cause input sets the matching vector bit on the next clock edge and clears any bit set earlier. Bit positions: 0 auxiliary power loss or refresh, 1 AC power fail, 2 power-converter fail, 3 ASIC thermal shutdown, 4 halt or hotswap, 5 watchdog from the CPU module, 6 watchdog from the switch board, 7 watchdog from the mezzanine, 8 firmware reset, 9 long button press, 10 short button press, 11 software reset.
- R4: When several strobes are high in one cycle, the lowest-numbered bit is recorded, so power-loss causes win over all others.
- R5: The system reset input clears neither the cause vector nor the capture pulse, and a strobe that arrives while system reset is high is still recorded.
- R6: The capture pulse is high for exactly the cycle after each cycle with any strobe, including a repeat of the cause already stored, and low otherwise.
- R7: A read request is acknowledged in the next cycle. Address 0 returns the cause vector in bits 11:0. Address 1 returns the binary number of the recorded bit in bits 3:0 and a record-present flag in bit 15. Addresses 2 and 3 return zero.
- R8: A write request is acknowledged with data zero and leaves the cause vector unchanged.
- R9: In a cycle with no strobe the cause vector holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset; clears only the bus response logic |
| cause_strobe | input | 12 | One strobe per reset cause |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | Access is a write (ignored by the record) |
| bus_addr | input | 2 | Register address |
| bus_ack | output | 1 | Access acknowledge, one cycle after request |
| bus_rdata | output | 16 | Read data |
| cause_vec | output | 12 | One-hot last-reset cause |
| cause_new | output | 1 | One-cycle pulse after a capture |

## Verification
A corrupted record shows up at cause_vec one edge after the offending strobe, either as a second set bit or as the wrong survivor of a collision. Every random step compares it against a priority model. A record lost to system reset shows up in the first compare after sys_rst. A bad encoder or address decode shows up in bus_rdata on the acknowledge cycle of the next read.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int NCAUSE = 12;
    localparam int IDX_W  = $clog2(NCAUSE);

    typedef logic [NCAUSE-1:0] cause_vec_t;

    typedef enum logic [IDX_W-1:0] {
        C_AUX_PWR   = 4'd0,
        C_AC_FAIL   = 4'd1,
        C_CONV_FAIL = 4'd2,
        C_THERMAL   = 4'd3,
        C_HALT_HS   = 4'd4,
        C_WD_CPU    = 4'd5,
        C_WD_SWB    = 4'd6,
        C_WD_MEZZ   = 4'd7,
        C_FW_RST    = 4'd8,
        C_PB_LONG   = 4'd9,
        C_PB_SHORT  = 4'd10,
        C_SW_RST    = 4'd11
    } cause_e;

    typedef enum logic [1:0] {
        REG_VEC = 2'd0,
        REG_IDX = 2'd1
    } reg_sel_e;

    typedef struct packed {
        logic       hit;
        cause_vec_t onehot;
    } pick_t;

    function automatic logic [IDX_W-1:0] onehot_to_idx(cause_vec_t v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NCAUSE; i++)
            if (v[i]) r = r | IDX_W'(i);
        return r;
    endfunction

endpackage

// File: rtl/rstc_prio_pick.sv
module rstc_prio_pick
    import rstc_pkg::*;
(
    input  cause_vec_t strobe,
    output pick_t      pick
);
    logic [NCAUSE:0] seen;
    cause_vec_t      win;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NCAUSE; g++) begin : g_chain
            assign win[g]    = strobe[g] & ~seen[g];
            assign seen[g+1] = seen[g] | strobe[g];
        end
    endgenerate

    assign pick.hit    = seen[NCAUSE];
    assign pick.onehot = win;
endmodule

// File: rtl/rstc_record.sv
module rstc_record
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  pick_t      pick,
    output cause_vec_t cause_q,
    output logic       new_q
);
    always_ff @(posedge clk) begin
        if (por_rst) begin
            cause_q <= '0;
            new_q   <= 1'b0;
        end else begin
            new_q <= pick.hit;
            if (pick.hit)
                cause_q <= pick.onehot;
        end
    end

    AST_ONE_HOT_REC: assert property (@(posedge clk) disable iff (por_rst)
        $onehot0(cause_q)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (por_rst)
        !pick.hit |=> $stable(cause_q)); // R9
    AST_PULSE_AFTER_HIT: assert property (@(posedge clk) disable iff (por_rst)
        pick.hit |=> new_q); // R6
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (por_rst)
        !pick.hit |=> !new_q); // R6
endmodule

// File: rtl/rstc_regbus.sv
module rstc_regbus
    import rstc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  cause_vec_t        cause,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLAG_BIT = DATA_W - 1;

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (!we) begin
            if (addr == ADDR_W'(REG_VEC)) begin
                rd_mux[NCAUSE-1:0] = cause;
            end else if (addr == ADDR_W'(REG_IDX)) begin
                rd_mux[IDX_W-1:0] = onehot_to_idx(cause);
                rd_mux[FLAG_BIT]  = |cause;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst || sys_rst) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= req;
            rdata <= req ? rd_mux : '0;
        end
    end

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (por_rst)
        (req && !sys_rst) |=> ack); // R7
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (por_rst)
        (req && we && !sys_rst) |=> (rdata == '0)); // R8
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (por_rst)
        (req && !we && !sys_rst && addr == ADDR_W'(REG_IDX))
            |=> (rdata[FLAG_BIT] == $past(|cause))); // R7
endmodule

// File: rtl/rstc_recorder.sv
module rstc_recorder
    import rstc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic [11:0]       cause_strobe,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [11:0]       cause_vec,
    output logic              cause_new
);
    pick_t      pick;
    cause_vec_t rec_q;
    logic       new_q;

    rstc_prio_pick u_pick (
        .strobe (cause_strobe),
        .pick   (pick)
    );

    rstc_record u_rec (
        .clk     (clk),
        .por_rst (por_rst),
        .pick    (pick),
        .cause_q (rec_q),
        .new_q   (new_q)
    );

    rstc_regbus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk     (clk),
        .por_rst (por_rst),
        .sys_rst (sys_rst),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .cause   (rec_q),
        .ack     (bus_ack),
        .rdata   (bus_rdata)
    );

    assign cause_vec = rec_q;
    assign cause_new = new_q;

    AST_POWER_WINS: assert property (@(posedge clk) disable iff (por_rst)
        cause_strobe[C_AUX_PWR] |=> cause_vec[C_AUX_PWR]); // R4
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (por_rst)
        (cause_strobe == 12'h800) |=> (cause_vec == 12'h800)); // R3
    AST_SYSRST_KEEP: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && cause_strobe == '0) |=> $stable(cause_vec)); // R5
endmodule

// File: tb/tb_rstc_recorder.sv
module tb_rstc_recorder;
    logic        clk = 1'b0;
    logic        por_rst, sys_rst;
    logic [11:0] cause_strobe;
    logic        bus_req, bus_we;
    logic [1:0]  bus_addr;
    logic        bus_ack;
    logic [15:0] bus_rdata;
    logic [11:0] cause_vec;
    logic        cause_new;

    int total = 0;
    int bad   = 0;
    logic [11:0] exp_vec;

    always #2 clk = ~clk;

    rstc_recorder dut (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
        .cause_strobe(cause_strobe), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .cause_vec(cause_vec), .cause_new(cause_new)
    );

    function automatic logic [11:0] model_pick(logic [11:0] s);
        for (int i = 0; i < 12; i++)
            if (s[i]) return 12'(1) << i;
        return '0;
    endfunction

    function automatic logic [15:0] model_idx(logic [11:0] v);
        logic [15:0] r = '0;
        for (int i = 0; i < 12; i++)
            if (v[i]) r = 16'h8000 | 16'(i);
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(logic [11:0] s, string req);
        cause_strobe = s;
        tick();
        if (s != 0) exp_vec = model_pick(s);
        chk(req, 32'(cause_vec), 32'(exp_vec));
        chk("R6", 32'(cause_new), 32'(s != 0));
        cause_strobe = '0;
    endtask

    task automatic rd(logic [1:0] a, logic w, logic [15:0] exp, string req);
        bus_req = 1'b1; bus_we = w; bus_addr = a;
        tick();
        bus_req = 1'b0; bus_we = 1'b0;
        chk(req, 32'(bus_ack), 32'd1);
        chk(req, 32'(bus_rdata), 32'(exp));
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        por_rst = 1'b1; sys_rst = 1'b0; cause_strobe = '0;
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
        exp_vec = '0;
        repeat (3) tick();
        por_rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", 32'(cause_vec), 0);
        chk("R1", 32'(cause_new), 0);
        rd(2'd0, 1'b0, 16'h0, "R1");
        rd(2'd1, 1'b0, 16'h0, "R1");

        // R3 single causes replace each other
        strobe(12'h200, "R3");
        strobe(12'h400, "R3");
        rd(2'd0, 1'b0, 16'h0400, "R7");
        rd(2'd1, 1'b0, 16'h800A, "R7");
        rd(2'd2, 1'b0, 16'h0, "R7");
        rd(2'd3, 1'b0, 16'h0, "R7");
        // R6 repeat of same cause still pulses
        strobe(12'h400, "R6");
        // R9 idle holds
        tick();
        chk("R9", 32'(cause_vec), 32'h400);
        chk("R6", 32'(cause_new), 0);

        // R4 collisions
        strobe(12'hFFF, "R4");
        strobe(12'hA30, "R4");
        strobe(12'h880, "R4");

        // R8 writes ignored
        rd(2'd0, 1'b1, 16'h0, "R8");
        chk("R8", 32'(cause_vec), 32'h080);
        rd(2'd0, 1'b0, 16'h0080, "R8");

        // R5 system reset keeps record, captures during reset
        sys_rst = 1'b1;
        tick();
        chk("R5", 32'(cause_vec), 32'h080);
        strobe(12'h010, "R5");
        sys_rst = 1'b0;
        tick();
        chk("R5", 32'(cause_vec), 32'h010);
        rd(2'd1, 1'b0, 16'h8004, "R5");

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [11:0] s;
            s = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
            if ($urandom % 5 == 0) s = 12'(1) << ($urandom % 12);
            sys_rst = ($urandom % 8 == 0);
            strobe(s, "R3");
            chk("R2", 32'($countones(cause_vec) <= 1), 1);
            if (n % 16 == 0) begin
                sys_rst = 1'b0;
                rd(2'd0, 1'b0, 16'(exp_vec), "R7");
                rd(2'd1, 1'b0, model_idx(exp_vec), "R7");
            end
        end
        sys_rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule